// File: doc/BRIEF.md
# Arithmetic Condition Flag Unit

This unit turns the outcome of an integer add, subtract, compare or negate into condition flags and holds them in a 32-bit status register. The arithmetic itself is done elsewhere. The unit receives:

- both operands;
- the result;
- the carry or borrow out of the top bit of the active width;
- a size code that selects an 8, 16 or 32-bit operation;
- an operation code.

When the update strobe is high, five flag bits at fixed, scattered positions are rewritten on the next clock edge. Every other bit of the register keeps its value.

A branch helper output follows the stored zero flag. A jump-if-equal decision can use it directly after a compare.

Compare is treated exactly like subtract for flag purposes, because its result is simply discarded by the caller. Negate is treated as zero minus the first operand. Parity always looks at the low eight bits of the result, whatever the operation size. Zero and sign look only at the bits inside the selected width.

Top module: `sflag_unit`

## Requirements
- R1: On an update, bit 0 of the flag register takes the value of the carry input, for every operation kind and size.
- R2: On an update, bit 2 is set when result bits 7..0 hold an even count of ones and cleared otherwise, for every operation size.
- R3: On an update, bit 6 is set when the result bits inside the selected width are all zero; result bits above that width have no effect.
- R4: On an update, bit 7 copies result bit 7, 15 or 31 for the 8, 16 or 32-bit size.
- R5: With op code 0 (add), bit 11 is set when both operand sign bits match and the result sign bit differs from them.
- R6: With op code 1 (subtract), bit 11 is set when the operand sign bits differ and the result sign bit differs from the first operand. With op code 3 (negate, computed as zero minus operand A), bit 11 is set only when operand A is the most negative value of the width.
- R7: With op code 2 (compare), all flags are updated exactly as for op code 1.
- R8: Size code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits.
- R9: While the update strobe is low, the whole flag register holds its value.
- R10: Bits other than 0, 2, 6, 7 and 11 never change after reset. Reset loads the register with RESET_FLAGS, default 0x0000_0202.
- R11: The eq_hit output equals bit 6 of the flag register in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Write the computed flags on this edge |
| op_kind | input | 2 | 0 add, 1 subtract, 2 compare, 3 negate |
| op_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| opnd_a | input | 32 | First operand (the negated value for negate) |
| opnd_b | input | 32 | Second operand |
| result | input | 32 | Result produced by the external datapath |
| carry_in | input | 1 | Carry or borrow out of the top bit of the active width |
| flags | output | 32 | Stored flag register |
| eq_hit | output | 1 | Zero flag, for jump-if-equal decisions |

## Verification
The bench sweeps every byte value of operand A against 64 operand B values that include 0x7F, 0x80 and 0xFF, for all four operations. Expected flags come from integer arithmetic and a signed range check, so a design that derives overflow from the wrong operand, or that mishandles negate of the most negative value, misses the boundary vectors.

Byte and halfword vectors place junk in the operand and result bits above the width. A unit that takes zero or sign from the full 32 bits, or parity from more than the low byte, reports wrong flags on those vectors. Cycles with the strobe low and the untouched register bits are also checked, which exposes a register that loads unconditionally or clobbers its preserved bits.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
    localparam int DATA_W  = 32;
    localparam int FLAG_W  = 32;
    localparam int BASE_W  = 8;
    localparam int N_LANES = 3;

    localparam int CF_POS = 0;
    localparam int PF_POS = 2;
    localparam int ZF_POS = 6;
    localparam int SF_POS = 7;
    localparam int OF_POS = 11;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_CMP = 2'd2,
        OP_NEG = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic zf;
        logic sf;
        logic of;
    } cond_t;

    function automatic logic [FLAG_W-1:0] cond_mask();
        logic [FLAG_W-1:0] m;
        m = '0;
        m[CF_POS] = 1'b1;
        m[PF_POS] = 1'b1;
        m[ZF_POS] = 1'b1;
        m[SF_POS] = 1'b1;
        m[OF_POS] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/sflag_parity.sv
module sflag_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits,
    output logic         even
);
    assign even = ~^bits;
endmodule

// File: rtl/sflag_width_sel.sv
module sflag_width_sel #(
    parameter int DATA_W  = 32,
    parameter int BASE_W  = 8,
    parameter int N_LANES = 3
) (
    input  logic [1:0]        size_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] result,
    output logic              msb_a,
    output logic              msb_b,
    output logic              msb_r,
    output logic              res_zero
);
    logic [N_LANES-1:0] lane_zero;
    logic [N_LANES-1:0] lane_ma;
    logic [N_LANES-1:0] lane_mb;
    logic [N_LANES-1:0] lane_mr;
    logic [1:0]         lane_idx;
    logic               unused_opnd_bits;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        localparam int LW = BASE_W << i;
        assign lane_zero[i] = ~|result[LW-1:0];
        assign lane_ma[i]   = opnd_a[LW-1];
        assign lane_mb[i]   = opnd_b[LW-1];
        assign lane_mr[i]   = result[LW-1];
    end

    assign unused_opnd_bits = ^{opnd_a, opnd_b};

    always_comb begin
        if (int'(size_code) >= N_LANES) lane_idx = 2'(N_LANES - 1);
        else                            lane_idx = size_code;
    end

    assign msb_a    = lane_ma[lane_idx];
    assign msb_b    = lane_mb[lane_idx];
    assign msb_r    = lane_mr[lane_idx];
    assign res_zero = lane_zero[lane_idx];
endmodule

// File: rtl/sflag_ovf.sv
module sflag_ovf
    import sflag_pkg::*;
(
    input  op_kind_e op_kind,
    input  logic     msb_a,
    input  logic     msb_b,
    input  logic     msb_r,
    output logic     ovf
);
    always_comb begin
        unique case (op_kind)
            OP_ADD:  ovf = (msb_a == msb_b) && (msb_r != msb_a);
            // negate is 0 - a: first operand sign is 0
            OP_NEG:  ovf = msb_a && msb_r;
            default: ovf = (msb_a != msb_b) && (msb_r != msb_a);
        endcase
    end
endmodule

// File: rtl/sflag_unit.sv
module sflag_unit
    import sflag_pkg::*;
#(
    parameter logic [FLAG_W-1:0] RESET_FLAGS = 32'h0000_0202
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [1:0]        op_kind,
    input  logic [1:0]        op_size,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] result,
    input  logic              carry_in,
    output logic [FLAG_W-1:0] flags,
    output logic              eq_hit
);
    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } state_t;

    state_t   st_d, st_q;
    cond_t    cond;
    op_kind_e op_e;
    logic     msb_a, msb_b, msb_r, res_zero, par_even, ovf;

    assign op_e = op_kind_e'(op_kind);

    sflag_width_sel #(
        .DATA_W (DATA_W),
        .BASE_W (BASE_W),
        .N_LANES(N_LANES)
    ) u_width (
        .size_code(op_size),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .result   (result),
        .msb_a    (msb_a),
        .msb_b    (msb_b),
        .msb_r    (msb_r),
        .res_zero (res_zero)
    );

    sflag_parity #(.W(BASE_W)) u_par (
        .bits(result[BASE_W-1:0]),
        .even(par_even)
    );

    sflag_ovf u_ovf (
        .op_kind(op_e),
        .msb_a  (msb_a),
        .msb_b  (msb_b),
        .msb_r  (msb_r),
        .ovf    (ovf)
    );

    always_comb begin
        cond.cf = carry_in;
        cond.pf = par_even;
        cond.zf = res_zero;
        cond.sf = msb_r;
        cond.of = ovf;
        st_d = st_q;
        if (upd_en) begin
            st_d.flags[CF_POS] = cond.cf;
            st_d.flags[PF_POS] = cond.pf;
            st_d.flags[ZF_POS] = cond.zf;
            st_d.flags[SF_POS] = cond.sf;
            st_d.flags[OF_POS] = cond.of;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.flags <= RESET_FLAGS;
        else        st_q       <= st_d;
    end

    assign flags  = st_q.flags;
    assign eq_hit = st_q.flags[ZF_POS];

    p_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> flags[CF_POS] == $past(carry_in));

    p_parity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> flags[PF_POS] == ~^$past(result[7:0]));

    p_zero_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_size == 2'd0 && result[7:0] == 8'h00) |=> flags[ZF_POS]);

    p_sign_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_size == 2'd0) |=> flags[SF_POS] == $past(result[7]));

    p_ovf_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_kind == 2'd0 && op_size == 2'd2 && opnd_a[31] == opnd_b[31]
         && result[31] != opnd_a[31]) |=> flags[OF_POS]);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(flags));

    p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flags & ~cond_mask()) == (RESET_FLAGS & ~cond_mask()));
endmodule

// File: tb/sim_sflag_unit.sv
`timescale 1ns/1ps
module sim_sflag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [1:0]  op_size = 2'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result = '0;
    logic        carry_in = 1'b0;
    logic [31:0] flags;
    logic        eq_hit;

    int total = 0;
    int bad = 0;
    logic [31:0] model = 32'h0000_0202;

    localparam logic [31:0] JUNK = 32'hA5C3_5A3C;

    always #4 clk = ~clk;

    sflag_unit u0 (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_kind(op_kind),
        .op_size(op_size), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .carry_in(carry_in), .flags(flags), .eq_hit(eq_hit)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input int op, input int szc, input longint a, input longint b, input bit en);
        int w;
        longint mask, sa, sb, res, sres, lim;
        bit cy, of;
        logic [31:0] m32;
        string pre;
        w    = (szc == 0) ? 8 : (szc == 1) ? 16 : 32;
        mask = (64'sd1 <<< w) - 1;
        m32  = 32'(mask);
        a    = a & mask;
        b    = b & mask;
        sa   = a[w-1] ? a - (64'sd1 <<< w) : a;
        sb   = b[w-1] ? b - (64'sd1 <<< w) : b;
        case (op)
            0: begin res = (a + b) & mask; cy = ((a + b) >>> w) != 0; sres = sa + sb; end
            3: begin res = (-a) & mask; cy = (a != 0); sres = -sa; end
            default: begin res = (a - b) & mask; cy = (a < b); sres = sa - sb; end
        endcase
        lim = 64'sd1 <<< (w - 1);
        of  = (sres > lim - 1) || (sres < -lim);
        opnd_a   = (JUNK & ~m32) | 32'(a);
        opnd_b   = (~JUNK & ~m32) | 32'(b);
        result   = (JUNK & ~m32) | 32'(res);
        carry_in = cy;
        op_kind  = 2'(op);
        op_size  = 2'(szc);
        upd_en   = en;
        if (en) begin
            model[0]  = cy;
            model[2]  = ($countones(8'(res)) % 2) == 0;
            model[6]  = (res == 0);
            model[7]  = ((res >>> (w - 1)) & 1) != 0;
            model[11] = of;
        end
        pre = en ? "" : "R9 ";
        if (op == 2) pre = {pre, "R7 "};
        if (szc == 3) pre = {pre, "R8 "};
        @(posedge clk);
        @(negedge clk);
        chk(flags[0] == model[0], {pre, "R1 carry"}, flags, model);
        chk(flags[2] == model[2], {pre, "R2 parity"}, flags, model);
        chk(flags[6] == model[6], {pre, "R3 zero"}, flags, model);
        chk(flags[7] == model[7], {pre, "R4 sign"}, flags, model);
        chk(flags[11] == model[11], {pre, (op == 0) ? "R5 overflow" : "R6 overflow"}, flags, model);
        chk(flags == model, {pre, "R10 full register"}, flags, model);
        chk(eq_hit == model[6], {pre, "R11 eq_hit"}, {31'd0, eq_hit}, {31'd0, model[6]});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        longint corner16 [8];
        longint corner32 [8];
        corner16 = '{0, 1, 'h7FFF, 'h8000, 'hFFFF, 'h00FF, 'h0100, 'h1234};
        corner32 = '{0, 1, 'h7FFF_FFFF, 'h8000_0000, 'hFFFF_FFFF, 'h0000_FFFF, 'h0001_0000, 'h89AB_CDEF};
        repeat (3) @(negedge clk);
        chk(flags == 32'h0000_0202, "R10 reset value", flags, 32'h0000_0202);
        chk(eq_hit == 1'b0, "R11 reset eq_hit", {31'd0, eq_hit}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int op = 0; op < 4; op++)
            for (int a = 0; a < 256; a++)
                for (int j = 0; j < 64; j++)
                    run_vec(op, 0, longint'(a), longint'(j * 4 + (j & 3)), 1'b1);
        for (int szc = 1; szc < 4; szc++)
            for (int op = 0; op < 4; op++)
                for (int i = 0; i < 8; i++)
                    for (int k = 0; k < 8; k++)
                        run_vec(op, szc, (szc == 1) ? corner16[i] : corner32[i],
                                (szc == 1) ? corner16[k] : corner32[k], 1'b1);
        for (int i = 0; i < 8; i++) begin
            run_vec(1, 2, corner32[i], corner32[7 - i], 1'b1);
            run_vec(0, 0, longint'(i * 37), longint'(255 - i * 11), 1'b0);
            run_vec(3, 2, corner32[i], 0, 1'b0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule